// File: doc/BRIEF.md
# Chained Monitor Readback Controller

This block is the host-side master that pulls measurement or register frames out of a daisy chain of up to eight battery-monitor devices over SPI. A single start pulse opens one burst. Chip select stays low for the whole burst. The first 32-bit slot carries a fixed read command. In every following slot the controller sends that same command again on SDI, while it shifts in one 32-bit frame from SDO.

The controller checks each incoming frame as it arrives:
- An 8-bit CRC is built serially over the leading 22 bits.
- The device address is put back into normal bit order, since it arrives least significant bit first.
- The remaining fields are split out according to the selected frame type (conversion or register).

Each checked frame is presented for one cycle with its fields, its acknowledge bit and a CRC-error flag. A done pulse follows the last frame. The number of frames per burst is the per-device conversion count (12, 9 or 6) times the number of devices.

Top module: `chain_readback_ctrl`

## Requirements
- R1: A synchronous reset, including one raised in the middle of a burst, puts the block in idle: `cs_n` high, `sclk` high, `busy` low. No `frm_valid` or `done` pulse appears afterwards until a new start.
- R2: `start` is accepted only while idle. A `start` raised during a burst has no effect on that burst's length or frame output.
- R3: `sclk` idles high and each half period lasts `CLK_DIV` clock cycles. SDI changes only on a falling edge of `sclk`. SDO is sampled on the rising edge.
- R4: During the burst, every 32-bit slot on SDI (the first one included) carries the command word 0xF800030A, most significant bit first.
- R5: `mode` 0 selects 12×8 = 96 frames, 1 selects 9×8 = 72 frames, and 2 or 3 select 6×8 = 48 frames. A burst has 32×(frames+1) rising edges of `sclk`, and the first 32 bits received are discarded.
- R6: With `frame_type` = 0 (conversion), `frm_addr` is zero-extended from the frame's bits 26..23. `frm_data` is bits 22..11. Bit 31 is the first bit on the wire and bit 0 is the last.
- R7: With `frame_type` = 1 (register), `frm_addr` is bits 26..21. `frm_data` is bits 20..13, zero-extended to 12 bits.
- R8: The first five bits on the wire (frame bits 31..27) are the device address, least significant bit first. `frm_dev` returns that address in normal order, so the first wire bit appears in `frm_dev[0]`.
- R9: A CRC with polynomial x^8+x^5+x^3+x^2+x+1, seed 0, runs over frame bits 31..10 in wire order. `frm_crc_err` is 1 exactly when the result differs from the value received in bits 9..2.
- R10: `frm_ack` equals frame bit 10.
- R11: `frm_valid` is a one-cycle pulse per frame, raised after the frame's last bit has been sampled. `done` pulses for one cycle in the cycle after the last frame's `frm_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a burst when idle |
| mode | input | 2 | Conversion count select (0:12, 1:9, 2/3:6) |
| frame_type | input | 1 | 0 conversion frames, 1 register frames |
| sdo | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Chip select, active low |
| sdi | output | 1 | Serial command data to the chain |
| busy | output | 1 | Burst in progress |
| frm_valid | output | 1 | One-cycle strobe per received frame |
| frm_dev | output | 5 | Device address in normal bit order |
| frm_addr | output | 6 | Channel or register address |
| frm_data | output | 12 | Conversion or register data |
| frm_ack | output | 1 | Write-acknowledge bit of the frame |
| frm_crc_err | output | 1 | CRC mismatch on the frame |
| done | output | 1 | One-cycle pulse after the last frame |

## Verification
Some properties are checked on every cycle:
- the one-cycle shape of `frm_valid`;
- `done` trailing a valid frame;
- valid frames appearing only inside a burst;
- SDI holding steady while `sclk` is high;
- `sclk` resting high outside a burst;
- the idle state after reset.

Other behaviour can only be shown by the bench's scenarios, which run bursts in each mode and both frame types with deliberately corrupted CRCs:
- field extraction;
- address reordering;
- CRC error detection;
- the exact frame and edge counts;
- the repeated command on SDI;
- the ignored mid-burst start;
- the abort on reset.

// File: rtl/chain_readback_ctrl.sv
module chain_readback_ctrl #(
  parameter int          CLK_DIV  = 2,
  parameter int          DEVICES  = 8,
  parameter logic [31:0] READ_CMD = 32'hF800030A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        frame_type,
  input  logic        sdo,
  output logic        sclk,
  output logic        cs_n,
  output logic        sdi,
  output logic        busy,
  output logic        frm_valid,
  output logic [4:0]  frm_dev,
  output logic [5:0]  frm_addr,
  output logic [11:0] frm_data,
  output logic        frm_ack,
  output logic        frm_crc_err,
  output logic        done
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int FW = $clog2(12 * DEVICES + 1);
  localparam logic [7:0] POLY = 8'h2F;

  logic [DW-1:0] div_cnt;
  logic [4:0]    bit_cnt;
  logic [FW-1:0] frm_cnt, frm_total;
  logic          type_q, last_pend;
  logic [30:0]   sh;
  logic [7:0]    crc;

  wire        tick   = busy && (div_cnt == DW'(CLK_DIV - 1));
  wire [31:0] fr     = {sh, sdo};
  wire [7:0]  crc_in = (bit_cnt == 5'd0) ? 8'h00 : crc;
  wire [7:0]  crc_nx = {crc_in[6:0], 1'b0} ^ ((crc_in[7] ^ sdo) ? POLY : 8'h00);

  function automatic logic [FW-1:0] total_of(input logic [1:0] m);
    case (m)
      2'd0:    total_of = FW'(12 * DEVICES);
      2'd1:    total_of = FW'(9 * DEVICES);
      default: total_of = FW'(6 * DEVICES);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cs_n <= 1'b1; sclk <= 1'b1; sdi <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; frm_cnt <= '0; frm_total <= '0;
      type_q <= 1'b0; last_pend <= 1'b0; sh <= '0; crc <= '0;
      frm_valid <= 1'b0; done <= 1'b0; frm_dev <= '0; frm_addr <= '0;
      frm_data <= '0; frm_ack <= 1'b0; frm_crc_err <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      done      <= last_pend;
      last_pend <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          cs_n      <= 1'b0;
          div_cnt   <= '0;
          bit_cnt   <= '0;
          frm_cnt   <= '0;
          frm_total <= total_of(mode);
          type_q    <= frame_type;
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + DW'(1);
        if (tick && sclk) begin
          sclk <= 1'b0;
          sdi  <= READ_CMD[5'd31 - bit_cnt];
        end
        if (tick && !sclk) begin
          sclk    <= 1'b1;
          sh      <= {sh[29:0], sdo};
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt <= 5'd21) crc <= crc_nx;
          if (bit_cnt == 5'd31) begin
            frm_cnt <= frm_cnt + FW'(1);
            if (frm_cnt != '0) begin
              frm_valid   <= 1'b1;
              frm_dev     <= {fr[27], fr[28], fr[29], fr[30], fr[31]};
              frm_ack     <= fr[10];
              frm_crc_err <= (crc != fr[9:2]);
              frm_addr    <= type_q ? fr[26:21] : {2'b00, fr[26:23]};
              frm_data    <= type_q ? {4'h0, fr[20:13]} : fr[22:11];
            end
            if (frm_cnt == frm_total) begin
              busy      <= 1'b0;
              cs_n      <= 1'b1;
              last_pend <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cs_n && sclk && !busy && !frm_valid && !done));

  assert_sdi_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && $past(sclk)) |-> $stable(sdi));

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  assert_valid_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> $past(!cs_n));

  assert_valid_single_R11: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid);

  assert_done_after_valid_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(frm_valid));
endmodule

// File: tb/tb_chain_readback_ctrl.sv
module tb_chain_readback_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam logic [31:0] CMD = 32'hF800030A;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, frame_type = 1'b0, sdo = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sclk, cs_n, sdi, busy, frm_valid, frm_ack, frm_crc_err, done;
  logic [4:0] frm_dev;
  logic [5:0] frm_addr;
  logic [11:0] frm_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chain_readback_ctrl #(.CLK_DIV(DIV), .DEVICES(8), .READ_CMD(CMD)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .frame_type(frame_type),
    .sdo(sdo), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .busy(busy),
    .frm_valid(frm_valid), .frm_dev(frm_dev), .frm_addr(frm_addr),
    .frm_data(frm_data), .frm_ack(frm_ack), .frm_crc_err(frm_crc_err), .done(done));

  typedef struct {
    logic [4:0] dev; logic [5:0] addr; logic [11:0] data; logic ack; logic err;
  } item_t;

  item_t exp_q[$];
  bit    stream[$];
  int    sidx, checks, fails, cyc;
  bit    skip, cur_type;
  int    valids, dones, last_valid_cyc, done_cyc, rises, sdi_bad, sdi_hi_chg, gap_bad, last_chg;
  logic  prev_sclk = 1'b1, prev_sdi = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] crc_calc(input logic [21:0] d);
    logic [7:0] c = 8'h00;
    for (int k = 21; k >= 0; k--) begin
      logic fb;
      fb = c[7] ^ d[k];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h2F : 8'h00);
    end
    return c;
  endfunction

  always @(negedge cs_n) sidx = 0;
  always @(negedge sclk) if (!cs_n) begin
    sdo = (sidx < stream.size()) ? stream[sidx] : 1'b0;
    sidx++;
  end

  always @(negedge clk) begin
    item_t e;
    cyc++;
    if (!skip) begin
      if (sclk != prev_sclk) begin
        if (last_chg >= 0 && cyc - last_chg != DIV) gap_bad++;
        last_chg = cyc;
        if (sclk) begin
          rises++;
          if (sdi !== CMD[31 - ((rises - 1) % 32)]) sdi_bad++;
        end
      end else if (sclk && !cs_n && sdi !== prev_sdi) sdi_hi_chg++;
      if (frm_valid) begin
        valids++;
        last_valid_cyc = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected frame", valids, 0);
        else begin
          e = exp_q.pop_front();
          chk(frm_dev == e.dev, "R8", "device address", int'(frm_dev), int'(e.dev));
          chk(frm_addr == e.addr, cur_type ? "R7" : "R6", "address field", int'(frm_addr), int'(e.addr));
          chk(frm_data == e.data, cur_type ? "R7" : "R6", "data field", int'(frm_data), int'(e.data));
          chk(frm_ack == e.ack, "R10", "ack bit", int'(frm_ack), int'(e.ack));
          chk(frm_crc_err == e.err, "R9", "crc error flag", int'(frm_crc_err), int'(e.err));
        end
      end
      if (done) begin
        dones++;
        done_cyc = cyc;
      end
    end
    prev_sclk = sclk;
    prev_sdi = sdi;
  end

  task automatic run_burst(input int m, input bit typ, input int seed, input bit extra);
    int n = (m == 0) ? 12 : (m == 1) ? 9 : 6;
    int frames = n * 8;
    stream.delete();
    repeat (32) stream.push_back(1'b0);
    for (int i = 0; i < frames; i++) begin
      logic [31:0] w;
      logic [4:0] dv;
      logic [7:0] cr;
      item_t e;
      dv = 5'((i * 7 + seed) % 32);
      w = '0;
      for (int b = 0; b < 5; b++) w[31 - b] = dv[b];
      if (!typ) begin
        w[26:23] = 4'((i + seed) % 16);
        w[22:11] = 12'((i * 397 + seed * 31) % 4096);
        e.addr = {2'b00, w[26:23]};
        e.data = w[22:11];
      end else begin
        w[26:21] = 6'((i * 5 + seed) % 64);
        w[20:13] = 8'((i * 29 + seed) % 256);
        e.addr = w[26:21];
        e.data = {4'h0, w[20:13]};
      end
      w[10] = ((i + seed) % 3) != 0;
      cr = crc_calc(w[31:10]);
      e.err = ((i + seed) % 5) == 2;
      w[9:2] = e.err ? (cr ^ (8'h01 << (i % 8))) : cr;
      e.dev = dv;
      e.ack = w[10];
      exp_q.push_back(e);
      for (int k = 31; k >= 0; k--) stream.push_back(w[k]);
    end
    valids = 0; dones = 0; rises = 0; sdi_bad = 0; sdi_hi_chg = 0; gap_bad = 0;
    last_chg = -1; cur_type = typ;
    @(negedge clk);
    mode = 2'(m); frame_type = typ; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (500) @(negedge clk);
      mode = 2'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (dones == 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(valids == frames, "R5", "frame count", valids, frames);
    chk(rises == 32 * (frames + 1), "R5", "sclk rising edges", rises, 32 * (frames + 1));
    chk(sdi_bad == 0, "R4", "command bit mismatches", sdi_bad, 0);
    chk(sdi_hi_chg == 0 && gap_bad == 0, "R3", "sdi/sclk timing faults", sdi_hi_chg + gap_bad, 0);
    chk(dones == 1, "R11", "done pulses", dones, 1);
    chk(done_cyc == last_valid_cyc + 1, "R11", "done cycle after last valid", done_cyc, last_valid_cyc + 1);
    chk(exp_q.size() == 0, "R5", "frames left unread", exp_q.size(), 0);
    chk(busy == 0 && cs_n == 1, "R1", "idle after burst", int'(busy), 0);
    if (extra) begin
      repeat (200) @(negedge clk);
      chk(valids == frames && busy == 0, "R2", "frames after ignored start", valids, frames);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && busy == 0, "R1", "reset idle outputs", int'({cs_n, sclk, busy}), 6);
    chk(frm_valid == 0 && done == 0, "R1", "no strobes after reset", int'({frm_valid, done}), 0);
    run_burst(0, 1'b0, 1, 1'b0);
    run_burst(1, 1'b1, 2, 1'b0);
    run_burst(2, 1'b0, 3, 1'b0);
    run_burst(3, 1'b1, 4, 1'b1);
    skip = 1'b1;
    stream.delete();
    @(negedge clk);
    mode = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3000) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && busy == 0, "R1", "abort returns idle", int'({cs_n, sclk, busy}), 6);
    v = 0;
    repeat (300) begin
      @(negedge clk);
      if (frm_valid || done) v++;
    end
    chk(v == 0, "R1", "strobes after abort", v, 0);
    exp_q.delete();
    skip = 1'b0;
    run_burst(2, 1'b1, 5, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule